// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Unit

This block holds the status flags of a multi-master I2C peripheral and turns them into a single interrupt request. The serial shift engine sends it one-cycle strobes. These report a received byte that is ready for the receive data register, a transmit byte taken by the output shifter, and the ninth clock of a byte. With the ninth-clock strobe come the calling-address result, the direction bit and the acknowledge bit. A level input reports that the CRC byte buffer is full. The CPU side reads an 8-bit status word and writes it with a strobe. It also signals when it reads the receive data register and when it writes the transmit data register.

The block also decides whether a received byte may enter the receive data register. A byte is accepted only while the register is empty. A byte that arrives while it is full is dropped, and a one-cycle overrun pulse marks the loss. The two interrupt flags are cleared by writing 0 to their bit positions. A set event in the same cycle overrides that clear. The address-match flag changes only on ninth-clock boundaries.

Top module: `i2c_stat_flags`

## Requirements
- R1: The status word is, from bit 7 to bit 0: receive interrupt flag, transmit interrupt flag, address match, slave read/write, received acknowledge, CRC buffer full, transmit buffer empty, receive buffer full. After reset it reads 8'h0A.
- R2: `rx_load` is high in the same cycle as `rx_byte_vld` when `en` is high and bit 0 is low. In the following cycle, bit 0 and bit 7 both read 1.
- R3: While bit 0 is 1, `rx_load` stays low, the incoming byte is dropped and `rx_ovr` pulses high in that cycle. A `cpu_rx_rd` strobe clears bit 0 in the next cycle and leaves bit 7 unchanged.
- R4: A status write with bit 7 or bit 6 at 0 clears that flag. Writing 1 to either bit has no effect. Written values of bits 5..0 have no effect.
- R5: While `en` is low, bits 7 and 6 read 0 from the next cycle on, and no received byte is loaded.
- R6: When a clearing write and a set event for the same interrupt flag occur in one cycle, the flag reads 1.
- R7: `tx_load` with `en` high sets bit 6. `tx_load` sets bit 1, and `cpu_tx_wr` clears bit 1. When both occur in one cycle, bit 1 reads 0.
- R8: `irq` equals `irq_en` AND (bit 7 OR bit 6).
- R9: At an enabled ninth clock with `rx_is_addr` high, bit 5 takes the value of `addr_hit`. On a hit, bit 4 takes `dir_bit`.
- R10: At an enabled ninth clock with `rx_is_addr` low, bit 5 clears unless `slv_tx_mode` is high, in which case it holds.
- R11: Every enabled ninth clock copies `ack_bit` into bit 3. Bit 2 follows `crc_full` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Peripheral enable |
| irq_en | input | 1 | Interrupt enable |
| rx_byte_vld | input | 1 | Shifter has a received byte for the data register |
| cpu_rx_rd | input | 1 | CPU reads the receive data register |
| tx_load | input | 1 | Transmit register moved into the output shifter |
| cpu_tx_wr | input | 1 | CPU writes the transmit data register |
| ninth_clk | input | 1 | Ninth SCL clock of a byte |
| rx_is_addr | input | 1 | Current byte is a calling address |
| addr_hit | input | 1 | Calling address matched (own or extended) |
| slv_tx_mode | input | 1 | Block is in slave transmit |
| dir_bit | input | 1 | Read/write bit of the calling address |
| ack_bit | input | 1 | Acknowledge bit sampled on the ninth clock |
| crc_full | input | 1 | CRC byte buffer full |
| st_wr | input | 1 | CPU write strobe for the status word |
| st_wdata | input | 8 | CPU write data for the status word |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request |
| rx_load | output | 1 | Received byte accepted into the data register |
| rx_ovr | output | 1 | Received byte dropped because the buffer is full |

## Verification
A stuck or stale receive-buffer-full state shows up in the same cycle as the next `rx_byte_vld`, because `rx_load` and `rx_ovr` then take the wrong values. A wrong interrupt flag shows on `irq` and on the status word in the cycle after the event that caused it. An address-match flag that is cleared on the wrong ninth clock stays hidden until the status word is read after that clock. For that reason the bench checks every status bit in every cycle against its own flag model.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic rxif;
        logic txif;
        logic match;
        logic srw;
        logic rxak;
        logic crcbf;
        logic tbe;
        logic rbf;
    } stat_t;

    localparam stat_t STAT_RST = '{rxif: 1'b0, txif: 1'b0, match: 1'b0, srw: 1'b0,
                                   rxak: 1'b1, crcbf: 1'b0, tbe: 1'b1, rbf: 1'b0};
    localparam int BIT_RXIF = 7;
    localparam int BIT_TXIF = 6;
endpackage

// File: rtl/i2c_rx_flags.sv
module i2c_rx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rx_byte_vld,
    input  logic cpu_rx_rd,
    input  logic clr_rxif,
    output logic rxif,
    output logic rbf,
    output logic rx_load,
    output logic rx_ovr
);
    typedef struct packed {
        logic rxif;
        logic rbf;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   load_ok;

    always_comb begin
        load_ok = en && rx_byte_vld && !st_q.rbf;
        st_d    = st_q;
        // buffer full: a load fills it, a CPU read empties it
        if (load_ok)
            st_d.rbf = 1'b1;
        else if (cpu_rx_rd)
            st_d.rbf = 1'b0;
        // interrupt flag: the set event takes priority over a clearing write
        if (!en)
            st_d.rxif = 1'b0;
        else if (load_ok)
            st_d.rxif = 1'b1;
        else if (clr_rxif)
            st_d.rxif = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rxif    = st_q.rxif;
    assign rbf     = st_q.rbf;
    assign rx_load = load_ok;
    assign rx_ovr  = en && rx_byte_vld && st_q.rbf;
endmodule

// File: rtl/i2c_tx_flags.sv
module i2c_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tx_load,
    input  logic cpu_tx_wr,
    input  logic clr_txif,
    output logic txif,
    output logic tbe
);
    typedef struct packed {
        logic txif;
        logic tbe;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a CPU write refills the register, so it wins over the shifter move
        if (cpu_tx_wr)
            st_d.tbe = 1'b0;
        else if (tx_load)
            st_d.tbe = 1'b1;
        if (!en)
            st_d.txif = 1'b0;
        else if (tx_load)
            st_d.txif = 1'b1;
        else if (clr_txif)
            st_d.txif = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{txif: 1'b0, tbe: 1'b1};
        else
            st_q <= st_d;
    end

    assign txif = st_q.txif;
    assign tbe  = st_q.tbe;
endmodule

// File: rtl/i2c_ninth_capture.sv
module i2c_ninth_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ninth_clk,
    input  logic rx_is_addr,
    input  logic addr_hit,
    input  logic slv_tx_mode,
    input  logic dir_bit,
    input  logic ack_bit,
    input  logic crc_full,
    output logic match,
    output logic srw,
    output logic rxak,
    output logic crcbf
);
    typedef struct packed {
        logic match;
        logic srw;
        logic rxak;
        logic crcbf;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.crcbf = crc_full;
        if (en && ninth_clk) begin
            st_d.rxak = ack_bit;
            if (rx_is_addr) begin
                st_d.match = addr_hit;
                if (addr_hit)
                    st_d.srw = dir_bit;
            end else if (!slv_tx_mode) begin
                // a received data byte ends the match; bytes sent as slave do not
                st_d.match = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{match: 1'b0, srw: 1'b0, rxak: 1'b1, crcbf: 1'b0};
        else
            st_q <= st_d;
    end

    assign match = st_q.match;
    assign srw   = st_q.srw;
    assign rxak  = st_q.rxak;
    assign crcbf = st_q.crcbf;
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              irq_en,
    input  logic              rx_byte_vld,
    input  logic              cpu_rx_rd,
    input  logic              tx_load,
    input  logic              cpu_tx_wr,
    input  logic              ninth_clk,
    input  logic              rx_is_addr,
    input  logic              addr_hit,
    input  logic              slv_tx_mode,
    input  logic              dir_bit,
    input  logic              ack_bit,
    input  logic              crc_full,
    input  logic              st_wr,
    input  logic [STAT_W-1:0] st_wdata,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              rx_load,
    output logic              rx_ovr
);
    stat_t st;
    logic  clr_rxif, clr_txif;

    // only the two interrupt flag positions respond to writes, and only to a 0
    assign clr_rxif = st_wr && !st_wdata[BIT_RXIF];
    assign clr_txif = st_wr && !st_wdata[BIT_TXIF];

    i2c_rx_flags u_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .rx_byte_vld(rx_byte_vld),
        .cpu_rx_rd(cpu_rx_rd), .clr_rxif(clr_rxif), .rxif(st.rxif),
        .rbf(st.rbf), .rx_load(rx_load), .rx_ovr(rx_ovr)
    );

    i2c_tx_flags u_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .tx_load(tx_load),
        .cpu_tx_wr(cpu_tx_wr), .clr_txif(clr_txif), .txif(st.txif), .tbe(st.tbe)
    );

    i2c_ninth_capture u_cap (
        .clk(clk), .rst_n(rst_n), .en(en), .ninth_clk(ninth_clk),
        .rx_is_addr(rx_is_addr), .addr_hit(addr_hit), .slv_tx_mode(slv_tx_mode),
        .dir_bit(dir_bit), .ack_bit(ack_bit), .crc_full(crc_full),
        .match(st.match), .srw(st.srw), .rxak(st.rxak), .crcbf(st.crcbf)
    );

    assign status = st;
    assign irq    = irq_en && (st.rxif || st.txif);
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       irq_en,
    input logic       rx_byte_vld,
    input logic       cpu_rx_rd,
    input logic       tx_load,
    input logic       ninth_clk,
    input logic       rx_is_addr,
    input logic       slv_tx_mode,
    input logic [7:0] status,
    input logic       irq,
    input logic       rx_load,
    input logic       rx_ovr
);
    a_r2_load_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> (status[7] && status[0]));
    a_r3_no_load_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && rx_byte_vld) |-> !rx_load);
    a_r3_ovr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> status[0]);
    a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rx_rd && !rx_load) |=> !status[0]);
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (status[7:6] == 2'b00));
    a_r7_txload_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_load) |=> status[6]);
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
    a_r10_data_clears_match: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ninth_clk && !rx_is_addr && !slv_tx_mode) |=> !status[5]);
    a_r10_slave_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ninth_clk && !rx_is_addr && slv_tx_mode) |=> $stable(status[5]));
endmodule

bind i2c_stat_flags i2c_stat_flags_chk chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .irq_en(irq_en), .rx_byte_vld(rx_byte_vld),
    .cpu_rx_rd(cpu_rx_rd), .tx_load(tx_load), .ninth_clk(ninth_clk),
    .rx_is_addr(rx_is_addr), .slv_tx_mode(slv_tx_mode), .status(status),
    .irq(irq), .rx_load(rx_load), .rx_ovr(rx_ovr)
);

// File: tb/i2c_stat_flags_tb_top.sv
module i2c_stat_flags_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en, irq_en, rx_byte_vld, cpu_rx_rd, tx_load, cpu_tx_wr, ninth_clk;
    logic rx_is_addr, addr_hit, slv_tx_mode, dir_bit, ack_bit, crc_full, st_wr;
    logic [7:0] st_wdata;
    logic [7:0] status;
    logic irq, rx_load, rx_ovr;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench flag model
    logic m_rxif, m_txif, m_match, m_srw, m_rxak, m_crcbf, m_tbe, m_rbf;

    always #5 clk = ~clk;

    i2c_stat_flags dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .irq_en(irq_en), .rx_byte_vld(rx_byte_vld),
        .cpu_rx_rd(cpu_rx_rd), .tx_load(tx_load), .cpu_tx_wr(cpu_tx_wr),
        .ninth_clk(ninth_clk), .rx_is_addr(rx_is_addr), .addr_hit(addr_hit),
        .slv_tx_mode(slv_tx_mode), .dir_bit(dir_bit), .ack_bit(ack_bit),
        .crc_full(crc_full), .st_wr(st_wr), .st_wdata(st_wdata), .status(status),
        .irq(irq), .rx_load(rx_load), .rx_ovr(rx_ovr)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_word();
        return {m_rxif, m_txif, m_match, m_srw, m_rxak, m_crcbf, m_tbe, m_rbf};
    endfunction

    task automatic idle();
        en = 1'b1; irq_en = 1'b0; rx_byte_vld = 1'b0; cpu_rx_rd = 1'b0;
        tx_load = 1'b0; cpu_tx_wr = 1'b0; ninth_clk = 1'b0; rx_is_addr = 1'b0;
        addr_hit = 1'b0; slv_tx_mode = 1'b0; dir_bit = 1'b0; ack_bit = 1'b0;
        crc_full = 1'b0; st_wr = 1'b0; st_wdata = 8'h00;
    endtask

    // inputs are already driven at a falling edge; check, advance one cycle, check
    task automatic step();
        logic exp_load, exp_ovr;
        logic n_rxif, n_txif, n_match, n_srw, n_rxak, n_tbe, n_rbf;
        #1;
        exp_load = en && rx_byte_vld && !m_rbf;
        exp_ovr  = en && rx_byte_vld && m_rbf;
        chk("R2 rx_load", {7'd0, rx_load}, {7'd0, exp_load});
        chk("R3 rx_ovr", {7'd0, rx_ovr}, {7'd0, exp_ovr});
        chk("R8 irq", {7'd0, irq}, {7'd0, irq_en && (m_rxif || m_txif)});
        n_rbf  = exp_load ? 1'b1 : (cpu_rx_rd ? 1'b0 : m_rbf);
        n_rxif = !en ? 1'b0 : (exp_load ? 1'b1 : ((st_wr && !st_wdata[7]) ? 1'b0 : m_rxif));
        n_txif = !en ? 1'b0 : (tx_load ? 1'b1 : ((st_wr && !st_wdata[6]) ? 1'b0 : m_txif));
        n_tbe  = cpu_tx_wr ? 1'b0 : (tx_load ? 1'b1 : m_tbe);
        n_match = m_match; n_srw = m_srw; n_rxak = m_rxak;
        if (en && ninth_clk) begin
            n_rxak = ack_bit;
            if (rx_is_addr) begin
                n_match = addr_hit;
                if (addr_hit) n_srw = dir_bit;
            end else if (!slv_tx_mode) begin
                n_match = 1'b0;
            end
        end
        @(posedge clk);
        m_rbf = n_rbf; m_rxif = n_rxif; m_txif = n_txif; m_tbe = n_tbe;
        m_match = n_match; m_srw = n_srw; m_rxak = n_rxak; m_crcbf = crc_full;
        @(negedge clk);
        chk("R2 rxif", {7'd0, status[7]}, {7'd0, m_rxif});
        chk("R7 txif", {7'd0, status[6]}, {7'd0, m_txif});
        chk("R9 match", {7'd0, status[5]}, {7'd0, m_match});
        chk("R9 srw", {7'd0, status[4]}, {7'd0, m_srw});
        chk("R11 rxak", {7'd0, status[3]}, {7'd0, m_rxak});
        chk("R11 crcbf", {7'd0, status[2]}, {7'd0, m_crcbf});
        chk("R7 tbe", {7'd0, status[1]}, {7'd0, m_tbe});
        chk("R3 rbf", {7'd0, status[0]}, {7'd0, m_rbf});
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle();
        m_rxif = 0; m_txif = 0; m_match = 0; m_srw = 0;
        m_rxak = 1; m_crcbf = 0; m_tbe = 1; m_rbf = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset word", status, 8'h0A);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", status, 8'h0A);

        // R2/R3: load, then overrun, then CPU read
        idle(); rx_byte_vld = 1; step();
        chk("R2 rxif and rbf set", status & 8'h81, 8'h81);
        idle(); rx_byte_vld = 1; #1;
        chk("R3 load blocked", {7'd0, rx_load}, 8'd0);
        chk("R3 overrun pulse", {7'd0, rx_ovr}, 8'd1);
        step();
        idle(); cpu_rx_rd = 1; step();
        chk("R3 read clears rbf, keeps rxif", status & 8'h81, 8'h80);

        // R4: writing ones changes nothing, writing zero clears rxif only
        idle(); st_wr = 1; st_wdata = 8'hFF; step();
        chk("R4 write ones ignored", status, model_word());
        chk("R4 rxif kept", {7'd0, status[7]}, 8'd1);
        idle(); st_wr = 1; st_wdata = 8'h40; step();
        chk("R4 write zero clears rxif", {7'd0, status[7]}, 8'd0);

        // R6: clear and set of txif in one cycle
        idle(); tx_load = 1; st_wr = 1; st_wdata = 8'h00; step();
        chk("R6 set beats clear", {7'd0, status[6]}, 8'd1);
        idle(); irq_en = 1; step();
        // R7: CPU write wins over shifter move for tbe
        idle(); tx_load = 1; cpu_tx_wr = 1; step();
        chk("R7 cpu write wins tbe", {7'd0, status[1]}, 8'd0);

        // R5: disable forces interrupt flags off and blocks loads
        idle(); en = 0; rx_byte_vld = 1; #1;
        chk("R5 no load while disabled", {7'd0, rx_load}, 8'd0);
        step();
        chk("R5 flags off", {6'd0, status[7:6]}, 8'd0);

        // R9/R10: address match lifecycle
        idle(); ninth_clk = 1; rx_is_addr = 1; addr_hit = 1; dir_bit = 1; step();
        chk("R9 match set", status & 8'h30, 8'h30);
        idle(); ninth_clk = 1; slv_tx_mode = 1; step();
        chk("R10 slave transmit keeps match", {7'd0, status[5]}, 8'd1);
        idle(); ninth_clk = 1; step();
        chk("R10 data byte clears match", {7'd0, status[5]}, 8'd0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            en          = ($urandom % 16) != 0;
            irq_en      = $urandom % 2;
            rx_byte_vld = ($urandom % 4) == 0;
            cpu_rx_rd   = ($urandom % 5) == 0;
            tx_load     = ($urandom % 5) == 0;
            cpu_tx_wr   = ($urandom % 5) == 0;
            ninth_clk   = ($urandom % 3) == 0;
            rx_is_addr  = $urandom % 2;
            addr_hit    = $urandom % 2;
            slv_tx_mode = $urandom % 2;
            dir_bit     = $urandom % 2;
            ack_bit     = $urandom % 2;
            crc_full    = $urandom % 2;
            st_wr       = ($urandom % 6) == 0;
            st_wdata    = 8'($urandom);
            step();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule